// File: doc/BRIEF.md
# Timer Interrupt Reinjection Tracker

This block sits between a periodic timer tick source and a single interrupt line. A consumer that is slow to service interrupts must not lose timer expiries. The block therefore keeps a backlog count of expiries that are still outstanding and hands them out one at a time. A new interrupt pulse is issued only after the consumer has acknowledged the previous one.

Each tick adds one to the backlog, and each acknowledge removes one. An internal "acknowledged" flag gates delivery. A delivery emits a one-cycle pulse on the interrupt line and drops the flag until the next acknowledge arrives. Unmasking the interrupt or reprogramming the timer throws the backlog away and re-arms the flag. Reset does the same. A pending output shows whether any backlog remains.

Top module: `tick_reinject_tracker`

## Requirements
- R1: While and after reset (rst_n low, asynchronous, active low), the backlog is zero, the acknowledged flag is set, irq_o is low and pending_o is low.
- R2: A tick with no acknowledge and no clear event adds one to the backlog. The backlog saturates at 2^CNT_W-1, which is 255 for the default width of 8.
- R3: An acknowledge with no tick and no clear event removes one from the backlog. An acknowledge when the backlog is zero leaves it at zero.
- R4: A tick and an acknowledge in the same cycle are applied as a floored decrement followed by a saturating increment. A nonzero backlog is therefore unchanged, including at 255, and a zero backlog becomes one.
- R5: In a cycle where the backlog is nonzero, the acknowledged flag is set and no clear event is present, a delivery takes place. irq_o is high during the following cycle.
- R6: A delivery clears the acknowledged flag, so no further pulse is issued until an acknowledge is seen, however many ticks arrive. If an acknowledge coincides with a delivery, the delivery wins and the flag ends up cleared.
- R7: An acknowledge sets the acknowledged flag, also when the backlog is zero.
- R8: An unmask event or a reprogram event clears the backlog to zero and sets the acknowledged flag on the next edge. It suppresses any delivery in that cycle and overrides a tick or acknowledge in the same cycle.
- R9: pending_o is high exactly when the backlog is nonzero.
- R10: irq_o is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One timer expiry in this cycle |
| ack_i | input | 1 | Consumer acknowledges the last interrupt |
| unmask_i | input | 1 | Interrupt line unmasked; discards the backlog |
| reprog_i | input | 1 | Timer reprogrammed; discards the backlog |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pending_o | output | 1 | Backlog is nonzero |

## Verification
The hardest state to reach from the ports is a saturated backlog. Reaching it needs at least 255 more ticks than acknowledges with no clear event in between, and random stimulus with a clear event every hundred cycles never gets there. A directed burst of 300 ticks with acknowledge held low drives the backlog to saturation. A tick together with an acknowledge is then applied at the ceiling. The backlog is measured by counting the acknowledges needed for pending_o to fall. Random traffic, with acknowledges racing deliveries, then covers the flag interplay against a bench model.

// File: rtl/tick_reinject_pkg.sv
package tick_reinject_pkg;

  // Kind of update applied to the backlog in one cycle.
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_INC   = 2'd1,
    UPD_DEC   = 2'd2,
    UPD_CLEAR = 2'd3
  } upd_kind_t;

  // Decide the backlog update. The acknowledge is taken first with a floor at
  // zero, then the tick with a ceiling at full.
  function automatic upd_kind_t classify_update(
    input logic tick,
    input logic ack,
    input logic clr,
    input logic at_zero,
    input logic at_full
  );
    upd_kind_t k;
    if (clr)                k = UPD_CLEAR;
    else if (tick && !ack)  k = at_full ? UPD_HOLD : UPD_INC;
    else if (ack && !tick)  k = at_zero ? UPD_HOLD : UPD_DEC;
    else if (tick && ack)   k = at_zero ? UPD_INC  : UPD_HOLD;
    else                    k = UPD_HOLD;
    return k;
  endfunction

  // Next value of the acknowledged flag: clear events re-arm it, a delivery
  // consumes it, an acknowledge restores it.
  function automatic logic next_acked(
    input logic cur,
    input logic clr,
    input logic deliver,
    input logic ack
  );
    logic n;
    if (clr)          n = 1'b1;
    else if (deliver) n = 1'b0;
    else if (ack)     n = 1'b1;
    else              n = cur;
    return n;
  endfunction

endpackage

// File: rtl/tick_backlog_counter.sv
module tick_backlog_counter
  import tick_reinject_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ack,
  input  logic             clear,
  output logic [CNT_W-1:0] count_o,
  output logic             nonzero_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;
  logic             at_full;
  upd_kind_t        upd_kind;

  function automatic logic [CNT_W-1:0] apply_update(
    input logic [CNT_W-1:0] cur,
    input upd_kind_t        kind
  );
    logic [CNT_W-1:0] r;
    case (kind)
      UPD_INC:   r = cur + CNT_ONE;
      UPD_DEC:   r = cur - CNT_ONE;
      UPD_CLEAR: r = '0;
      default:   r = cur;
    endcase
    return r;
  endfunction

  assign at_zero  = (cnt_q == '0);
  assign at_full  = (cnt_q == CNT_MAX);
  assign upd_kind = classify_update(tick, ack, clear, at_zero, at_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= apply_update(cnt_q, upd_kind);
  end

  assign count_o   = cnt_q;
  assign nonzero_o = !at_zero;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && ack && !tick && !clear) |=> (cnt_q == '0)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (at_full && tick && !ack && !clear) |=> (cnt_q == CNT_MAX)); // R2
  AST_TICK_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_zero && tick && ack && !clear) |=> $stable(cnt_q)); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/tick_delivery_gate.sv
module tick_delivery_gate
  import tick_reinject_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic clear,
  input  logic backlog_nz,
  output logic acked_o,
  output logic deliver_o,
  output logic irq_o
);

  logic acked_q;
  logic irq_q;
  logic deliver;

  assign deliver = acked_q && backlog_nz && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acked_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      acked_q <= next_acked(acked_q, clear, deliver, ack);
      irq_q   <= deliver;
    end
  end

  assign acked_o   = acked_q;
  assign deliver_o = deliver;
  assign irq_o     = irq_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R10
  AST_DELIVER_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> !acked_q); // R6
  AST_ACK_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !deliver) |=> acked_q); // R7
  AST_CLEAR_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acked_q && !irq_q)); // R8

endmodule

// File: rtl/tick_reinject_tracker.sv
module tick_reinject_tracker #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ack_i,
  input  logic unmask_i,
  input  logic reprog_i,
  output logic irq_o,
  output logic pending_o
);

  logic             clear_evt;
  logic [CNT_W-1:0] backlog;
  logic             backlog_nz;
  logic             acked;
  logic             deliver_evt;

  assign clear_evt = unmask_i || reprog_i;

  tick_backlog_counter #(.CNT_W(CNT_W)) u_backlog (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_i),
    .ack       (ack_i),
    .clear     (clear_evt),
    .count_o   (backlog),
    .nonzero_o (backlog_nz)
  );

  tick_delivery_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack_i),
    .clear      (clear_evt),
    .backlog_nz (backlog_nz),
    .acked_o    (acked),
    .deliver_o  (deliver_evt),
    .irq_o      (irq_o)
  );

  assign pending_o = backlog_nz;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(acked && (backlog != '0))); // R5
  AST_PENDING_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending_o) |-> $past(ack_i || unmask_i || reprog_i)); // R9
  AST_DELIVER_NEEDS_BACKLOG: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_evt |-> pending_o); // R5

endmodule

// File: tb/tick_reinject_tracker_tb.sv
module tick_reinject_tracker_tb;

  localparam int CNT_W   = 8;
  localparam int MAXV    = (1 << CNT_W) - 1;
  localparam int WD_LIMIT = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, ack_i = 1'b0, unmask_i = 1'b0, reprog_i = 1'b0;
  logic irq_o, pending_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int   m_cnt;
  logic m_acked;
  logic m_irq;

  always #10 clk = ~clk;

  tick_reinject_tracker #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ack_i(ack_i),
    .unmask_i(unmask_i), .reprog_i(reprog_i),
    .irq_o(irq_o), .pending_o(pending_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int model_next(int c, logic t, logic a);
    int v = c;
    if (a && v > 0) v = v - 1;
    if (t && v < MAXV) v = v + 1;
    return v;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Called at a negedge; applies inputs for one cycle, checks at next negedge.
  task automatic step(input logic t, input logic a, input logic u, input logic r,
                      input string tag);
    logic clr, dlv;
    tick_i = t; ack_i = a; unmask_i = u; reprog_i = r;
    @(posedge clk);
    clr = u | r;
    dlv = m_acked && (m_cnt != 0) && !clr;
    m_irq = dlv;
    if (clr) begin
      m_cnt = 0; m_acked = 1'b1;
    end else begin
      m_cnt = model_next(m_cnt, t, a);
      if (dlv)    m_acked = 1'b0;
      else if (a) m_acked = 1'b1;
    end
    @(negedge clk);
    check(irq_o, m_irq, {tag, " irq"});
    check(pending_o, (m_cnt != 0), {tag, " pending R9"});
  endtask

  initial begin
    int acks;
    logic prev_irq;
    void'($urandom(32'd1234));
    m_cnt = 0; m_acked = 1'b1; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    check(irq_o, 1'b0, "R1 irq in reset");
    check(pending_o, 1'b0, "R1 pending in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_o, 1'b0, "R1 irq after reset");
    check(pending_o, 1'b0, "R1 pending after reset");

    // R5: first tick delivers with acked set
    step(1, 0, 0, 0, "R2 tick");
    step(0, 0, 0, 0, "R5 deliver");
    // R6: more ticks, no pulse until ack; R10 pulse width
    step(1, 0, 0, 0, "R10 width");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R6 no pulse without ack");
    step(0, 1, 0, 0, "R7 ack");
    step(0, 0, 0, 0, "R5 redeliver");
    // R3 drain to zero and beyond
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, "R3 ack floor");
    // R7 ack at zero arms flag, then R4 tick+ack at zero gives one
    step(1, 1, 0, 0, "R4 tick ack at zero");
    step(0, 0, 0, 0, "R5 deliver after zero");
    step(1, 1, 0, 0, "R4 tick ack nonzero");
    // R8 clear events
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R2 build");
    step(1, 1, 1, 0, "R8 unmask");
    step(0, 0, 0, 0, "R8 after unmask");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R2 build");
    step(0, 0, 0, 1, "R8 reprogram");
    step(0, 0, 0, 0, "R8 after reprogram");

    // R2 saturation burst
    for (int i = 0; i < 300; i++) step(1, 0, 0, 0, "R2 saturate");
    step(1, 1, 0, 0, "R4 tick ack at full");
    acks = 0;
    while (pending_o && acks < 400) begin
      step(0, 1, 0, 0, "R3 drain");
      acks++;
    end
    checks++;
    if (acks != MAXV) begin
      errors++;
      $display("FAIL R2 saturated backlog: actual %0d expected %0d", acks, MAXV);
    end

    // Random traffic, model-checked; R10 watched directly
    prev_irq = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      logic t, a, u, r;
      t = ($urandom_range(99) < 35);
      a = ($urandom_range(99) < 30);
      u = ($urandom_range(199) == 0);
      r = ($urandom_range(199) == 0);
      step(t, a, u, r, "R5 random");
      if (prev_irq && irq_o) check(1'b1, 1'b0, "R10 back-to-back pulse");
      prev_irq = irq_o;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule